// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is an I2C target in front of a 2048-byte memory, arranged as eight blocks of 256 bytes. A bus master reaches any byte in three ways. A current-address read fetches the byte the internal pointer already holds. A random read first sets the pointer with a short write phase and then reads. A sequential read streams consecutive bytes for as long as the master keeps acknowledging.

SCL and SDA arrive asynchronously. Each line passes through a two-flop synchroniser and a stable-sample filter before any edge is decoded. The target never drives SDA high. It only asserts an open-drain pull-down enable. A parallel backdoor write port loads the array contents, so a test or boot agent can preload the memory.

One 11-bit pointer serves both reads and the address-setting write. The three block bits of each accepted control byte become the upper pointer bits. The word-address byte sets the lower eight bits.

Top module: `i2cmem_top`

## Requirements
- R1: A control byte whose upper four bits equal 1010 is acknowledged: SDA is pulled low for the ninth clock. Any other value is not acknowledged, and the bus is then ignored until the next START.
- R2: Control byte bits 3:1 load pointer bits 10:8 on every accepted control byte. Bit 0 selects read (1) or write (0).
- R3: In write mode the next byte is the word address. It is acknowledged and loads pointer bits 7:0. A repeated START right after it keeps that pointer, so the following read returns the byte at {block, word}.
- R4: Bytes that follow the word address in write mode are not acknowledged. They change neither the array nor the pointer.
- R5: A read returns the byte at the pointer, and the pointer then advances by one. Two reads in a row therefore return n and then n+1.
- R6: A master acknowledge after a data byte makes the target send the byte at the next address. A master non-acknowledge followed by STOP leaves SDA released.
- R7: The pointer carries from block to block, for example from 0x0FF to 0x100, and wraps from 0x7FF to 0x000.
- R8: Data goes out most significant bit first, and the target changes its SDA drive only while SCL is low.
- R9: A pulse on SCL or SDA shorter than FILT_LEN clock cycles has no effect on the transfer.
- R10: With bdWe high, bdData is written to the array at bdAddr on the clock edge.
- R11: After reset SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line as seen on the wire, asynchronous |
| sdaOe | output | 1 | Pull SDA low when 1 |
| bdWe | input | 1 | Backdoor write enable |
| bdAddr | input | ADDR_W (11) | Backdoor byte address |
| bdData | input | 8 | Backdoor write data |

## Verification
The bench builds the block with its defaults: ADDR_W = 11, FILT_LEN = 3 and control code 1010. At ADDR_W = 11 the pointer's top address 0x7FF can be reached, so the bench can check the wrap to 0 and a carry across a block boundary inside one sequential burst. FILT_LEN = 3 makes a two-cycle SCL spike the longest pulse that must be rejected, and the bench injects exactly that pulse inside a control byte.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

  typedef struct packed {
    logic rxSample;
    logic setBlk;
    logic setWord;
    logic incPtr;
    logic txLoad;
    logic txShift;
    logic txEn;
    logic ackEn;
  } i2cStrobe_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RXCTRL,
    S_ACKC,
    S_RXADDR,
    S_ACKA,
    S_RXSKIP,
    S_SKIPNAK,
    S_TX,
    S_RACK
  } i2cState_t;

endpackage

// File: rtl/i2cmem_filter.sv
module i2cmem_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic lvl,
  output logic rose,
  output logic fell
);
  logic [1:0]          syncQ;
  logic [FILT_LEN-1:0] hist;
  logic                lvlD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
      hist  <= '1;
      lvl   <= 1'b1;
      lvlD  <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      hist  <= {hist[FILT_LEN-2:0], syncQ[1]};
      if (&hist)       lvl <= 1'b1;
      else if (~|hist) lvl <= 1'b0;
      lvlD <= lvl;
    end
  end

  assign rose = lvl & ~lvlD;
  assign fell = ~lvl & lvlD;
endmodule

// File: rtl/i2cmem_ctrl.sv
module i2cmem_ctrl
  import i2cmem_pkg::*;
#(
  parameter logic [3:0] CTRL_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       sdaLvl,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [7:0] rxByte,
  output i2cStrobe_t stb
);
  i2cState_t  state, stateN;
  logic [3:0] bitCnt, cntN;
  logic       rwQ, rwN, mAckQ, mAckN;

  always_comb begin
    stateN = state;
    cntN   = bitCnt;
    rwN    = rwQ;
    mAckN  = mAckQ;
    stb    = '0;
    stb.txEn  = (state == S_TX);
    stb.ackEn = (state == S_ACKC) || (state == S_ACKA);
    if (startEv) begin
      stateN = S_RXCTRL;
      cntN   = 4'd0;
    end else if (stopEv) begin
      stateN = S_IDLE;
    end else begin
      case (state)
        S_RXCTRL, S_RXADDR, S_RXSKIP: begin
          if (sclRise && bitCnt != 4'd8) begin
            stb.rxSample = 1'b1;
            cntN = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            cntN = 4'd0;
            if (state == S_RXCTRL) begin
              if (rxByte[7:4] == CTRL_CODE) begin
                stb.setBlk = 1'b1;
                rwN    = rxByte[0];
                stateN = S_ACKC;
              end else begin
                stateN = S_IDLE;
              end
            end else if (state == S_RXADDR) begin
              stb.setWord = 1'b1;
              stateN = S_ACKA;
            end else begin
              stateN = S_SKIPNAK;
            end
          end
        end
        S_ACKC: if (sclFall) begin
          cntN = 4'd0;
          if (rwQ) begin
            stb.txLoad = 1'b1;
            stateN = S_TX;
          end else begin
            stateN = S_RXADDR;
          end
        end
        S_ACKA, S_SKIPNAK: if (sclFall) begin
          cntN   = 4'd0;
          stateN = S_RXSKIP;
        end
        S_TX: if (sclFall) begin
          if (bitCnt == 4'd7) begin
            stb.incPtr = 1'b1;
            stateN = S_RACK;
          end else begin
            stb.txShift = 1'b1;
            cntN = bitCnt + 4'd1;
          end
        end
        S_RACK: begin
          if (sclRise) mAckN = ~sdaLvl;
          if (sclFall) begin
            if (mAckQ) begin
              stb.txLoad = 1'b1;
              cntN   = 4'd0;
              stateN = S_TX;
            end else begin
              stateN = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= 4'd0;
      rwQ    <= 1'b0;
      mAckQ  <= 1'b0;
    end else begin
      state  <= stateN;
      bitCnt <= cntN;
      rwQ    <= rwN;
      mAckQ  <= mAckN;
    end
  end
endmodule

// File: rtl/i2cmem_dpath.sv
module i2cmem_dpath
  import i2cmem_pkg::*;
#(
  parameter int ADDR_W = 11,
  localparam int BLK_W = ADDR_W - 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  i2cStrobe_t        stb,
  input  logic              sdaLvl,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [7:0]        bdData,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaOe
);
  logic [7:0] mem [DEPTH];
  logic [7:0] txByte;

  always_ff @(posedge clk) begin
    if (bdWe) mem[bdAddr] <= bdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txByte <= '0;
      ptr    <= '0;
    end else begin
      if (stb.rxSample) rxByte <= {rxByte[6:0], sdaLvl};
      if (stb.setWord)      ptr[7:0]        <= rxByte;
      else if (stb.setBlk)  ptr[ADDR_W-1:8] <= rxByte[BLK_W:1];
      else if (stb.incPtr)  ptr             <= ptr + ADDR_W'(1);
      if (stb.txLoad)       txByte <= mem[ptr];
      else if (stb.txShift) txByte <= {txByte[6:0], 1'b0};
    end
  end

  assign sdaOe = (stb.txEn & ~txByte[7]) | stb.ackEn;
endmodule

// File: rtl/i2cmem_top.sv
module i2cmem_top
  import i2cmem_pkg::*;
#(
  parameter int         ADDR_W    = 11,
  parameter int         FILT_LEN  = 3,
  parameter logic [3:0] CTRL_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [7:0]        bdData
);
  logic sclLvl, sclRise, sclFall;
  logic sdaLvl, sdaRose, sdaFell;
  logic startEv, stopEv;
  logic [7:0]        rxByte;
  logic [ADDR_W-1:0] ptr;
  i2cStrobe_t        stb;

  i2cmem_filter #(.FILT_LEN(FILT_LEN)) u_sclFilt (
    .clk(clk), .rstN(rstN), .rawIn(sclIn),
    .lvl(sclLvl), .rose(sclRise), .fell(sclFall));

  i2cmem_filter #(.FILT_LEN(FILT_LEN)) u_sdaFilt (
    .clk(clk), .rstN(rstN), .rawIn(sdaIn),
    .lvl(sdaLvl), .rose(sdaRose), .fell(sdaFell));

  assign startEv = sdaFell & sclLvl;
  assign stopEv  = sdaRose & sclLvl;

  i2cmem_ctrl #(.CTRL_CODE(CTRL_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .sdaLvl(sdaLvl), .startEv(startEv), .stopEv(stopEv),
    .rxByte(rxByte), .stb(stb));

  i2cmem_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl),
    .bdWe(bdWe), .bdAddr(bdAddr), .bdData(bdData),
    .rxByte(rxByte), .ptr(ptr), .sdaOe(sdaOe));
endmodule

// File: rtl/i2cmem_chk.sv
module i2cmem_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLvl,
  input logic              sdaRose,
  input logic              sdaOe,
  input logic              incPtr,
  input logic              setBlk,
  input logic              setWord,
  input logic              txEn,
  input logic              ackEn,
  input logic [ADDR_W-1:0] ptr
);
  p_oe_scl_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe != $past(sdaOe)) |-> !sclLvl);

  p_stop_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sdaRose && sclLvl) |=> !sdaOe);

  p_ptr_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ptr != $past(ptr)) |-> ($past(incPtr) || $past(setBlk) || $past(setWord)));

  p_ptr_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(incPtr) && ($past(ptr) == {ADDR_W{1'b1}})) |-> (ptr == '0));

  p_one_driver_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txEn, ackEn}));
endmodule

bind i2cmem_top i2cmem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sdaRose(sdaRose), .sdaOe(sdaOe),
  .incPtr(stb.incPtr), .setBlk(stb.setBlk), .setWord(stb.setWord),
  .txEn(stb.txEn), .ackEn(stb.ackEn), .ptr(ptr));

// File: tb/sim_i2cmem_top.sv
module sim_i2cmem_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic bdWe = 1'b0;
  logic [10:0] bdAddr = '0;
  logic [7:0]  bdData = '0;
  logic sdaOe, busSda;
  logic [7:0] model [2048];
  int nChk = 0, nFail = 0, oeViol = 0;
  logic prevOe = 1'b0;

  always #2 clk = ~clk;

  assign busSda = mSda & ~sdaOe;

  i2cmem_top u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .sdaOe(sdaOe),
    .bdWe(bdWe), .bdAddr(bdAddr), .bdData(bdData));

  always @(posedge clk) begin
    if (rstN && (sdaOe != prevOe) && mScl) oeViol++;
    prevOe <= sdaOe;
  end

  function automatic logic [7:0] pat(input logic [10:0] a);
    return 8'(a[7:0] * 3 + a[10:8] * 29 + 1);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
  endtask

  task automatic waitQ;
    repeat (Q) @(negedge clk);
  endtask

  task automatic mStart;
    mSda = 1'b1; waitQ; mScl = 1'b1; waitQ; mSda = 1'b0; waitQ; mScl = 1'b0; waitQ;
  endtask

  task automatic mStop;
    mSda = 1'b0; waitQ; mScl = 1'b1; waitQ; mSda = 1'b1; waitQ; waitQ;
  endtask

  task automatic mBit(input logic b, input bit glitch);
    mSda = b; waitQ;
    if (glitch) begin
      mScl = 1'b1; @(negedge clk); @(negedge clk); mScl = 1'b0; waitQ;
    end
    mScl = 1'b1; waitQ; waitQ; mScl = 1'b0; waitQ;
  endtask

  task automatic mGetBit(output logic b);
    mSda = 1'b1; waitQ; mScl = 1'b1; waitQ; b = busSda; waitQ; mScl = 1'b0; waitQ;
  endtask

  task automatic mSend(input logic [7:0] v, input bit glitch, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) mBit(v[i], glitch && (i == 7));
    mGetBit(b);
    ack = ~b;
  endtask

  task automatic mRecv(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) mGetBit(v[i]);
    mBit(~ackIt, 1'b0);
  endtask

  task automatic bdWrite(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); bdWe = 1'b1; bdAddr = a; bdData = d;
    @(negedge clk); bdWe = 1'b0;
    model[a] = d;
  endtask

  // Write phase only: control byte in write mode plus word address.
  task automatic setAddr(input logic [10:0] a, input string req);
    logic ack;
    mStart;
    mSend({4'b1010, a[10:8], 1'b0}, 1'b0, ack);
    chk(req, "write control ack", ack, 1);
    mSend(a[7:0], 1'b0, ack);
    chk(req, "word address ack", ack, 1);
  endtask

  // START, read control byte, n bytes (ACK all but last), NACK, STOP.
  task automatic rdBurst(input logic [2:0] blk, input int n, input logic [10:0] a0,
                         input bit glitch, input string req);
    logic ack;
    logic [7:0] v;
    mStart;
    mSend({4'b1010, blk, 1'b1}, glitch, ack);
    chk(req, "read control ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      mRecv(k != n - 1, v);
      chk(req, $sformatf("data byte %0d", k), v, model[11'(a0 + 11'(k))]);
    end
    mStop;
  endtask

  task automatic t_reset;
    chk("R11", "sdaOe after reset", sdaOe, 0);
    for (int a = 0; a < 2048; a++) model[a] = pat(11'(a));
    @(negedge clk); bdWe = 1'b1;
    for (int a = 0; a < 2048; a++) begin
      bdAddr = 11'(a); bdData = pat(11'(a)); @(negedge clk);
    end
    bdWe = 1'b0;
    rdBurst(3'd0, 1, 11'h000, 1'b0, "R11");
    rdBurst(3'd0, 1, 11'h001, 1'b0, "R5");
  endtask

  task automatic t_random;
    setAddr(11'h5A3, "R3");
    rdBurst(3'd5, 1, 11'h5A3, 1'b0, "R3");
    rdBurst(3'd5, 1, 11'h5A4, 1'b0, "R5");
    rdBurst(3'd2, 1, 11'h2A5, 1'b0, "R2");
  endtask

  task automatic t_badcode;
    logic ack;
    mStart;
    mSend(8'h93, 1'b0, ack);
    chk("R1", "wrong code not acked", ack, 0);
    mSend(8'h00, 1'b0, ack);
    chk("R1", "following byte ignored", ack, 0);
    mStop;
    rdBurst(3'd2, 1, 11'h2A6, 1'b0, "R1");
  endtask

  task automatic t_extra;
    logic ack;
    setAddr(11'h033, "R3");
    mSend(8'hEE, 1'b0, ack);
    chk("R4", "extra write byte not acked", ack, 0);
    mStop;
    rdBurst(3'd0, 1, 11'h033, 1'b0, "R4");
  endtask

  task automatic t_seq;
    setAddr(11'h0FE, "R3");
    rdBurst(3'd0, 4, 11'h0FE, 1'b0, "R7");
    @(negedge clk);
    chk("R6", "SDA released after NACK and STOP", sdaOe, 0);
  endtask

  task automatic t_wrap;
    setAddr(11'h7FE, "R3");
    rdBurst(3'd7, 3, 11'h7FE, 1'b0, "R7");
    rdBurst(3'd0, 1, 11'h001, 1'b0, "R7");
  endtask

  task automatic t_glitch;
    setAddr(11'h123, "R3");
    rdBurst(3'd1, 2, 11'h123, 1'b1, "R9");
  endtask

  task automatic t_backdoor;
    bdWrite(11'h444, 8'h3C);
    setAddr(11'h444, "R10");
    rdBurst(3'd4, 1, 11'h444, 1'b0, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    t_reset;
    t_random;
    t_badcode;
    t_extra;
    t_seq;
    t_wrap;
    t_glitch;
    t_backdoor;
    // R8: target drive changes only while SCL low; MSB-first order checked by data compares
    chk("R8", "SDA drive changes while SCL high", oeViol, 0);
    summary;
    $finish;
  end
endmodule